// File: doc/BRIEF.md
# System Reset Controller with Cause Tracking

This block merges every source of a chip-wide reset into one internal reset line. The sources are an asynchronous external reset pin, a supply-low indication from an analog detector, a watchdog reset request and a software request for a system reset. The supply-low indication causes a reset only while software has enabled it. A sticky cause register records every source that has fired since software last cleared it, so start-up code can read why the chip came out of reset.

The block also drives one reset line per peripheral from three software-written bank registers. Each bank bit uses the same position as that unit's clock-gate bit. A set bit holds the unit in reset in every clock domain it has. Software reaches all registers through a simple single-cycle write port and a combinational read port. The analog detector, the watchdog counter and the processor's start-up fetch are outside the block.

Top module: `sys_rst_ctrl`

## Requirements
- R1: While `rst_ni` is low, `sys_rst_no` is low, the supply-low enable is 0, all bank registers are 0 and the cause register reads 5'b00001. `sys_rst_no` rises on the first clock edge after `rst_ni` rises, provided the external pin has been high for at least two edges.
- R2: A low level on `ext_rst_ni` drives `sys_rst_no` low at once, without a clock edge. After the pin rises, `sys_rst_no` stays low until the third rising clock edge. Cause bit 1 is set.
- R3: With the supply-low enable (address 0, bit 0) clear, `bod_low_i` has no effect on `sys_rst_no` and does not set cause bit 2.
- R4: With the enable set, `sys_rst_no` falls on the third clock edge after `bod_low_i` rises. It stays low until the third edge after `bod_low_i` falls, and cause bit 2 is set.
- R5: Writing 1 to bit 0 of address 5 drives `sys_rst_no` low for exactly HOLD_CYCLES (16) clock cycles, starting at the write edge. Cause bit 4 is set.
- R6: A sampled `wdt_rst_req_i` drives `sys_rst_no` low for exactly 16 cycles and sets cause bit 3. A new request during the hold restarts the 16-cycle count.
- R7: Cause bits (0 power-on, 1 external, 2 supply-low, 3 watchdog, 4 software) are sticky and read at address 1. Writing 1 to a bit clears it and writing 0 leaves it unchanged. When a source fires in the same cycle as a clear of its bit, the bit stays set.
- R8: Bank registers at addresses 2, 3 and 4 are read/write. Bit u of bank k drives `periph_rst_o[d*96 + k*32 + u]` high in every domain d.
- R9: While internal reset is active, all bank registers are cleared.
- R10: Register writes are ignored while `sys_rst_no` is low.
- R11: Address 0 reads the enable in bit 0. Unused bits, and addresses 5 to 7, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_ni | input | 1 | External reset pin, active low, asynchronous |
| bod_low_i | input | 1 | Supply-low indication from the analog detector, asynchronous |
| wdt_rst_req_i | input | 1 | Watchdog reset request |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for `reg_addr_i` |
| sys_rst_no | output | 1 | Chip-wide internal reset, active low |
| periph_rst_o | output | NUM_DOMAINS*3*DATA_W | Per-unit, per-domain reset lines, active high |

## Verification
Setting and clearing of a cause bit can fall in the same cycle. The bench provokes this by pulsing the watchdog request in the same cycle as a write-1 clear of the watchdog bit, then reads the bit back and requires it to be set. A second collision is a watchdog request that arrives while a hold is already counting. The bench issues it eight cycles into the hold and counts the low cycles, which must total 24. A behavioural model that is compared on every cycle judges both collisions, and so do explicit checks.

// File: rtl/sys_rst_ctrl_pkg.sv
package sys_rst_ctrl_pkg;
  localparam int ADDR_W    = 3;
  localparam int NUM_BANKS = 3;
  localparam int CAUSE_W   = 5;

  typedef enum logic [ADDR_W-1:0] {
    RA_PWR    = 3'd0,
    RA_CAUSE  = 3'd1,
    RA_BANK0  = 3'd2,
    RA_BANK1  = 3'd3,
    RA_BANK2  = 3'd4,
    RA_SYSREQ = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic sw;
    logic wdt;
    logic bod;
    logic ext;
    logic por;
  } cause_t;
endpackage

// File: rtl/sys_rst_sync.sv
module sys_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) q <= '0;
    else          q <= {q[STAGES-2:0], d_i};
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/sys_rst_hold.sv
module sys_rst_hold #(
  parameter int HOLD_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(HOLD_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (trig_i)     cnt_q <= LOAD;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/sys_rst_cause.sv
module sys_rst_cause
  import sys_rst_ctrl_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  cause_t set_i,
  input  cause_t clr_i,
  output cause_t q_o
);
  cause_t q;

  // set beats clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '{por: 1'b1, default: 1'b0};
    else         q <= (q & ~clr_i) | set_i;
  end

  assign q_o = q;
endmodule

// File: rtl/sys_rst_bank.sv
module sys_rst_bank #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (flush_i) q_o <= '0;
    else if (we_i)    q_o <= wdata_i;
  end
endmodule

// File: rtl/sys_rst_ctrl.sv
module sys_rst_ctrl
  import sys_rst_ctrl_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int NUM_DOMAINS = 2,
  parameter int HOLD_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  ext_rst_ni,
  input  logic                                  bod_low_i,
  input  logic                                  wdt_rst_req_i,
  input  logic                                  reg_we_i,
  input  logic [ADDR_W-1:0]                     reg_addr_i,
  input  logic [DATA_W-1:0]                     reg_wdata_i,
  output logic [DATA_W-1:0]                     reg_rdata_o,
  output logic                                  sys_rst_no,
  output logic [NUM_DOMAINS*NUM_BANKS*DATA_W-1:0] periph_rst_o
);
  localparam int UNITS = NUM_BANKS * DATA_W;
  localparam int OUT_W = NUM_DOMAINS * UNITS;

  logic              ext_sync, bod_sync, bod_act, ext_hold, hold_busy;
  logic              sys_rst_q, wr_en, sw_req, bod_en_q;
  logic              arst_n;
  cause_t            cause_q, cause_set, cause_clr;
  logic [UNITS-1:0]  bank_flat;
  reg_addr_e         addr;

  assign addr   = reg_addr_e'(reg_addr_i);
  assign arst_n = rst_ni & ext_rst_ni;

  // pin path: async assert, synchronous release
  sys_rst_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk_i, .arst_ni(ext_rst_ni), .d_i(1'b1), .q_o(ext_sync)
  );
  sys_rst_sync #(.STAGES(SYNC_STAGES)) u_bod_sync (
    .clk_i, .arst_ni(rst_ni), .d_i(bod_low_i), .q_o(bod_sync)
  );

  assign ext_hold = ~ext_sync;
  assign bod_act  = bod_sync & bod_en_q;
  assign wr_en    = reg_we_i & sys_rst_q;
  assign sw_req   = wr_en & (addr == RA_SYSREQ) & reg_wdata_i[0];

  sys_rst_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk_i, .rst_ni, .trig_i(sw_req | wdt_rst_req_i), .busy_o(hold_busy)
  );

  always_ff @(posedge clk_i or negedge arst_n) begin
    if (!arst_n) sys_rst_q <= 1'b0;
    else         sys_rst_q <= ~(ext_hold | bod_act | hold_busy | sw_req | wdt_rst_req_i);
  end
  assign sys_rst_no = sys_rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    bod_en_q <= 1'b0;
    else if (wr_en && addr == RA_PWR) bod_en_q <= reg_wdata_i[0];
  end

  always_comb begin
    cause_set = '{sw: sw_req, wdt: wdt_rst_req_i, bod: bod_act, ext: ext_hold, por: 1'b0};
    cause_clr = (wr_en && addr == RA_CAUSE) ? cause_t'(reg_wdata_i[CAUSE_W-1:0]) : '0;
  end

  sys_rst_cause u_cause (
    .clk_i, .rst_ni, .set_i(cause_set), .clr_i(cause_clr), .q_o(cause_q)
  );

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    logic bank_we;
    assign bank_we = wr_en && (reg_addr_i == ADDR_W'(int'(RA_BANK0) + k));
    sys_rst_bank #(.W(DATA_W)) u_bank (
      .clk_i, .rst_ni, .flush_i(~sys_rst_q), .we_i(bank_we),
      .wdata_i(reg_wdata_i), .q_o(bank_flat[k*DATA_W +: DATA_W])
    );
  end

  // every clock domain of a unit sees the same bank bit
  for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_dom
    assign periph_rst_o[d*UNITS +: UNITS] = bank_flat;
  end

  always_comb begin
    reg_rdata_o = '0;
    case (addr)
      RA_PWR:   reg_rdata_o[0] = bod_en_q;
      RA_CAUSE: reg_rdata_o[CAUSE_W-1:0] = cause_q;
      RA_BANK0: reg_rdata_o = bank_flat[0*DATA_W +: DATA_W];
      RA_BANK1: reg_rdata_o = bank_flat[1*DATA_W +: DATA_W];
      RA_BANK2: reg_rdata_o = bank_flat[2*DATA_W +: DATA_W];
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/sys_rst_ctrl_chk.sv
module sys_rst_ctrl_chk
  import sys_rst_ctrl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OUT_W  = 192
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sys_rst_no,
  input logic              wdt_rst_req_i,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [OUT_W-1:0]  periph_rst_o,
  input logic [CAUSE_W-1:0] cause_i,
  input logic              bod_en_i
);
  p_sw_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && sys_rst_no && reg_addr_i == 3'd5 && reg_wdata_i[0]) |=> !sys_rst_no);

  p_wdt_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_req_i |=> !sys_rst_no);

  p_cause_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && sys_rst_no && reg_addr_i == 3'd1)
      |=> ((cause_i & $past(cause_i)) == $past(cause_i)));

  p_bod_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cause_i[2]) |-> $past(bod_en_i));

  p_bank_flush_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_rst_no |=> (periph_rst_o == '0));

  p_write_locked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sys_rst_no && reg_we_i) |=> $stable(bod_en_i));
endmodule

bind sys_rst_ctrl sys_rst_ctrl_chk #(.DATA_W(DATA_W), .OUT_W(OUT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sys_rst_no(sys_rst_no),
  .wdt_rst_req_i(wdt_rst_req_i), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .periph_rst_o(periph_rst_o),
  .cause_i(cause_q), .bod_en_i(bod_en_q)
);

// File: tb/sys_rst_ctrl_test.sv
`timescale 1ns/1ps
module sys_rst_ctrl_test;
  localparam int DW = 32, ND = 2, HOLD = 16, NB = 3;
  localparam int OW = ND * NB * DW;

  logic clk_i = 0, rst_ni, ext_rst_ni, bod_low_i, wdt_rst_req_i, reg_we_i;
  logic [2:0]    reg_addr_i;
  logic [DW-1:0] reg_wdata_i, reg_rdata_o;
  logic          sys_rst_no;
  logic [OW-1:0] periph_rst_o;

  always #4 clk_i = ~clk_i;

  sys_rst_ctrl #(.DATA_W(DW), .NUM_DOMAINS(ND), .HOLD_CYCLES(HOLD)) uut (
    .clk_i, .rst_ni, .ext_rst_ni, .bod_low_i, .wdt_rst_req_i, .reg_we_i,
    .reg_addr_i, .reg_wdata_i, .reg_rdata_o, .sys_rst_no, .periph_rst_o
  );

  int vectors = 0, fails = 0, cycles = 0;
  string phase = "R1 power-on";

  // behavioural reference model
  int          m_ext_ok = 0, m_hold = 0;
  bit          m_rst = 0, m_bod_en = 0;
  bit [1:0]    m_bodq = 0;
  bit [4:0]    m_cause = 5'b00001;
  bit [DW-1:0] m_bank [NB];
  bit          o_ext_hold, o_bod, o_busy, o_run, m_wr, m_sw;

  always @(posedge clk_i) begin
    o_ext_hold = (m_ext_ok < 2);
    o_bod      = m_bodq[1] && m_bod_en;
    o_busy     = (m_hold > 0);
    o_run      = m_rst && ext_rst_ni;
    if (!ext_rst_ni) m_ext_ok = 0;
    else if (m_ext_ok < 2) m_ext_ok++;
    if (!rst_ni) begin
      m_rst = 0; m_bod_en = 0; m_bodq = 0; m_cause = 5'b00001; m_hold = 0;
      for (int k = 0; k < NB; k++) m_bank[k] = '0;
    end else begin
      m_wr = reg_we_i && o_run;
      m_sw = m_wr && reg_addr_i == 3'd5 && reg_wdata_i[0];
      if (!ext_rst_ni) m_rst = 0;
      else m_rst = !(o_ext_hold || o_bod || o_busy || m_sw || wdt_rst_req_i);
      if (m_sw || wdt_rst_req_i) m_hold = HOLD - 1;
      else if (o_busy) m_hold--;
      m_bodq = {m_bodq[0], bod_low_i};
      if (m_wr && reg_addr_i == 3'd1) m_cause &= ~reg_wdata_i[4:0];
      if (o_ext_hold)     m_cause[1] = 1;
      if (o_bod)          m_cause[2] = 1;
      if (wdt_rst_req_i)  m_cause[3] = 1;
      if (m_sw)           m_cause[4] = 1;
      if (m_wr && reg_addr_i == 3'd0) m_bod_en = reg_wdata_i[0];
      for (int k = 0; k < NB; k++) begin
        if (!o_run) m_bank[k] = '0;
        else if (m_wr && reg_addr_i == 3'(k + 2)) m_bank[k] = reg_wdata_i;
      end
    end
  end

  function automatic logic [DW-1:0] exp_rdata();
    case (reg_addr_i)
      3'd0: return {{(DW-1){1'b0}}, m_bod_en};
      3'd1: return {{(DW-5){1'b0}}, m_cause};
      3'd2: return m_bank[0];
      3'd3: return m_bank[1];
      3'd4: return m_bank[2];
      default: return '0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare();
    logic          e_rst;
    logic [OW-1:0] e_per;
    e_rst = m_rst & ext_rst_ni & rst_ni;
    e_per = {ND{m_bank[2], m_bank[1], m_bank[0]}};
    check(sys_rst_no === e_rst, {phase, " sys_rst_no"}, DW'(sys_rst_no), DW'(e_rst));
    check(reg_rdata_o === exp_rdata(), {phase, " rdata"}, reg_rdata_o, exp_rdata());
    check(periph_rst_o === e_per, {phase, " periph"}, periph_rst_o[DW-1:0], e_per[DW-1:0]);
  endtask

  task automatic cyc();
    @(negedge clk_i);
    compare();
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    cyc();
    reg_we_i = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [DW-1:0] e, input string tag);
    reg_addr_i = a;
    cyc();
    check(reg_rdata_o === e, tag, reg_rdata_o, e);
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int n;
    rst_ni = 0; ext_rst_ni = 1; bod_low_i = 0; wdt_rst_req_i = 0;
    reg_we_i = 0; reg_addr_i = 3'd1; reg_wdata_i = '0;
    repeat (4) cyc();
    check(sys_rst_no === 1'b0, "R1 held in reset", DW'(sys_rst_no), 0);
    rst_ni = 1;
    cyc();
    check(sys_rst_no === 1'b1, "R1 release", DW'(sys_rst_no), 1);
    rd(3'd1, 32'h1, "R1 cause power-on");
    rd(3'd0, 32'h0, "R1 enable clear");

    phase = "R11 map";
    wr(3'd0, 32'hFFFF_FFFE);
    rd(3'd0, 32'h0, "R11 unused bits");
    rd(3'd6, 32'h0, "R11 addr 6");
    rd(3'd7, 32'h0, "R11 addr 7");
    rd(3'd5, 32'h0, "R11 addr 5");

    phase = "R8 banks";
    wr(3'd2, 32'hA5A5_0F0F);
    wr(3'd3, 32'h8000_0001);
    wr(3'd4, 32'h1234_5678);
    rd(3'd3, 32'h8000_0001, "R8 readback");
    check(periph_rst_o[96+32] === 1'b1, "R8 domain1 unit32", DW'(periph_rst_o[96+32]), 1);
    check(periph_rst_o[95] === 1'b0, "R8 domain0 unit95", DW'(periph_rst_o[95]), 0);

    phase = "R5 software reset";
    wr(3'd5, 32'h1);
    n = sys_rst_no ? 0 : 1;
    for (int i = 0; i < 24; i++) begin
      if (i == 3) begin reg_we_i = 1; reg_addr_i = 3'd0; reg_wdata_i = 32'h1; end
      if (i == 5) begin reg_we_i = 1; reg_addr_i = 3'd1; reg_wdata_i = 32'h1F; end
      cyc();
      reg_we_i = 0;
      if (!sys_rst_no) n++;
    end
    check(n == HOLD, "R5 hold length", DW'(n), DW'(HOLD));
    rd(3'd0, 32'h0, "R10 enable write ignored");
    rd(3'd1, 32'h11, "R5 cause and R10 clear ignored");
    rd(3'd2, 32'h0, "R9 bank flushed");

    phase = "R7 clear";
    wr(3'd1, 32'h10);
    rd(3'd1, 32'h1, "R7 w1c");
    wr(3'd1, 32'h0);
    rd(3'd1, 32'h1, "R7 write 0 keeps");
    wr(3'd1, 32'h1);
    rd(3'd1, 32'h0, "R7 clear por");

    phase = "R6 watchdog";
    wdt_rst_req_i = 1;
    cyc();
    wdt_rst_req_i = 0;
    n = sys_rst_no ? 0 : 1;
    for (int i = 0; i < 40; i++) begin
      if (i == 7) wdt_rst_req_i = 1;
      cyc();
      wdt_rst_req_i = 0;
      if (!sys_rst_no) n++;
    end
    check(n == 24, "R6 restart hold", DW'(n), 24);
    rd(3'd1, 32'h8, "R6 cause");

    phase = "R7 collision";
    wdt_rst_req_i = 1; reg_we_i = 1; reg_addr_i = 3'd1; reg_wdata_i = 32'h8;
    cyc();
    wdt_rst_req_i = 0; reg_we_i = 0;
    repeat (20) cyc();
    rd(3'd1, 32'h8, "R7 set wins");
    wr(3'd1, 32'h8);
    rd(3'd1, 32'h0, "R7 cleared");

    phase = "R3 gated";
    bod_low_i = 1;
    for (int i = 0; i < 10; i++) begin
      cyc();
      check(sys_rst_no === 1'b1, "R3 no reset", DW'(sys_rst_no), 1);
    end
    bod_low_i = 0;
    rd(3'd1, 32'h0, "R3 no cause");

    phase = "R4 supply low";
    wr(3'd0, 32'h1);
    bod_low_i = 1;
    cyc(); cyc();
    check(sys_rst_no === 1'b1, "R4 before assert", DW'(sys_rst_no), 1);
    cyc();
    check(sys_rst_no === 1'b0, "R4 asserted", DW'(sys_rst_no), 0);
    repeat (9) cyc();
    bod_low_i = 0;
    cyc(); cyc();
    check(sys_rst_no === 1'b0, "R4 still held", DW'(sys_rst_no), 0);
    cyc();
    check(sys_rst_no === 1'b1, "R4 released", DW'(sys_rst_no), 1);
    rd(3'd1, 32'h4, "R4 cause");
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h4);

    phase = "R2 external";
    wr(3'd4, 32'hF);
    ext_rst_ni = 0;
    #1;
    check(sys_rst_no === 1'b0, "R2 async assert", DW'(sys_rst_no), 0);
    repeat (4) cyc();
    check(periph_rst_o === '0, "R9 flush on pin", periph_rst_o[DW-1:0], 0);
    ext_rst_ni = 1;
    cyc(); cyc();
    check(sys_rst_no === 1'b0, "R2 sync release pending", DW'(sys_rst_no), 0);
    cyc();
    check(sys_rst_no === 1'b1, "R2 released", DW'(sys_rst_no), 1);
    rd(3'd1, 32'h2, "R2 cause");

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule